// File: doc/BRIEF.md
# Serial Avionics Word Transmitter

This block sends one 32-bit avionics data word at a time on a three-level return-to-zero serial line. A host loads the word through two 16-bit writes that use a fixed, partly scrambled mapping between bus bits and word bits. The hardware computes the parity bit, so the host never supplies it. A start strobe begins transmission. A busy flag stays high for the whole word and for the quiet gap that follows it.

The line state is carried on two digital outputs. One output marks a high level and the other marks a low level. When both are low, the line is at null. A control input selects the bit rate: one bit lasts 10 or 80 master clocks. A second control input chooses odd or even parity. The same two outputs can also be wired back to a receiver for self-test.

Top module: `arinc_word_tx`

## Requirements
- R1: After reset `busy` is 0 and both `lineHigh` and `lineLow` are 0 (line null).
- R2: One bit period lasts 10 master clocks when `slowRate` is 0 and 80 when it is 1. The value is sampled when the start strobe is accepted.
- R3: A pulse on `wrHalfA` stores `wrData` as follows. Bus bits 15..11 become word bits 13..9. Bus bit 10 becomes word bit 31. Bus bit 9 becomes word bit 30. Bus bits 7..0 become word bits 1..8, with bus bit 7 as word bit 1.
- R4: A pulse on `wrHalfB` stores bus bits 15..0 as word bits 29..14, with bus bit 15 as word bit 29.
- R5: Bus bit 8 of a `wrHalfA` write is ignored. The transmitted word is the same whether it is 0 or 1.
- R6: Word bit 32 is the parity of bits 1..31. With `evenParity` at 0, the count of ones in bits 1..32 is odd. With `evenParity` at 1, it is even. `evenParity` is sampled at start.
- R7: Word bit 1 is sent first, then bits 2 through 32 in ascending order.
- R8: During the first half of each bit period the line shows ONE (`lineHigh`=1, `lineLow`=0) for a 1 bit, or ZERO (`lineHigh`=0, `lineLow`=1) for a 0 bit. During the second half it shows NULL (both 0). Both outputs are never high together.
- R9: A start strobe seen while `busy` is 0 begins a word on the next clock. `busy` is then high for 36 bit periods: 32 data bits and a 4-bit null gap. After that `busy` falls and a new start is accepted at once.
- R10: A start strobe while `busy` is 1 has no effect on the line or on the busy timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrHalfA | input | 1 | Write strobe for the scrambled half of the word |
| wrHalfB | input | 1 | Write strobe for word bits 29..14 |
| wrData | input | 16 | Host write data |
| slowRate | input | 1 | Bit rate select: 0 = 10 clocks per bit, 1 = 80 clocks per bit |
| evenParity | input | 1 | Parity select: 0 = odd, 1 = even |
| start | input | 1 | Start strobe for transmission |
| busy | output | 1 | High while a word or the gap after it is in progress |
| lineHigh | output | 1 | Line driven to the ONE level |
| lineLow | output | 1 | Line driven to the ZERO level |

## Verification
The line is compared cycle by cycle against a model built from the requirements. Words of all zeros, all ones and alternating bits separate the ONE, ZERO and NULL levels and show whether the parity sense is right. A walking one across all 31 payload positions exposes any swapped or reversed bit in either write half, and any mistake in send order. Other runs show that bus bit 8 has no effect, that the slow rate stretches every bit, and that a start strobe arriving mid-word leaves both the line and the gap timing untouched.

// File: rtl/arinc_tx_pkg.sv
package arinc_tx_pkg;
  localparam int WORD_BITS = 32;

  typedef struct packed {
    logic load;   // capture assembled word plus parity into shifter
    logic shift;  // advance to next bit
    logic drive;  // first half of a data bit: put bit on line
  } txStrobe_t;

  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_GAP} txState_e;
endpackage

// File: rtl/arinc_tx_ctrl.sv
module arinc_tx_ctrl
  import arinc_tx_pkg::*;
#(
  parameter int FAST_DIV = 10,
  parameter int SLOW_DIV = 80,
  parameter int GAP_BITS = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      slowRate,
  output txStrobe_t strb,
  output logic      busy
);
  localparam int CNT_W = $clog2(SLOW_DIV + 1);
  localparam int BIT_W = $clog2(WORD_BITS);
  localparam int GAP_W = $clog2(GAP_BITS + 1);

  txState_e         state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] divLen;
  logic [BIT_W-1:0] bitIdx;
  logic [GAP_W-1:0] gapIdx;
  logic             lastTick, lastBit, lastGap;

  assign lastTick = (cnt == divLen - CNT_W'(1));
  assign lastBit  = (bitIdx == BIT_W'(WORD_BITS - 1));
  assign lastGap  = (gapIdx == GAP_W'(GAP_BITS - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      divLen <= CNT_W'(FAST_DIV);
      bitIdx <= '0;
      gapIdx <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state  <= ST_SEND;
          cnt    <= '0;
          bitIdx <= '0;
          gapIdx <= '0;
          divLen <= slowRate ? CNT_W'(SLOW_DIV) : CNT_W'(FAST_DIV);
        end
        ST_SEND: if (lastTick) begin
          cnt <= '0;
          if (lastBit) state <= ST_GAP;
          else bitIdx <= bitIdx + BIT_W'(1);
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
        ST_GAP: if (lastTick) begin
          cnt <= '0;
          if (lastGap) state <= ST_IDLE;
          else gapIdx <= gapIdx + GAP_W'(1);
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.load  = (state == ST_IDLE) && start;
    strb.shift = (state == ST_SEND) && lastTick && !lastBit;
    strb.drive = (state == ST_SEND) && (cnt < (divLen >> 1));
    busy       = (state != ST_IDLE);
  end

  AST_PRESCALE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> cnt < divLen); // R2
  AST_START_ACCEPTED: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> busy); // R9
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SEND && start) |=> busy); // R10
  AST_GAP_BEFORE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(gapIdx) == GAP_W'(GAP_BITS - 1)); // R9
endmodule

// File: rtl/arinc_tx_dp.sv
module arinc_tx_dp
  import arinc_tx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      wrHalfA,
  input  logic      wrHalfB,
  input  logic [15:0] wrData,
  input  logic      evenParity,
  input  txStrobe_t strb,
  output logic      lineHigh,
  output logic      lineLow
);
  // payload[i] holds word bit i+1; bit 32 is generated at load
  logic [WORD_BITS-2:0] payload;
  logic [WORD_BITS-1:0] shReg;
  logic                 parBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      payload <= '0;
    end else begin
      if (wrHalfA) begin
        payload[12:8]  <= wrData[15:11];
        payload[30:29] <= wrData[10:9];
        for (int i = 0; i < 8; i++) payload[i] <= wrData[7-i];
      end
      if (wrHalfB) payload[28:13] <= wrData[15:0];
    end
  end

  assign parBit = evenParity ? (^payload) : ~(^payload);

  always_ff @(posedge clk) begin
    if (!rstN) shReg <= '0;
    else if (strb.load) shReg <= {parBit, payload};
    else if (strb.shift) shReg <= {1'b0, shReg[WORD_BITS-1:1]};
  end

  assign lineHigh = strb.drive & shReg[0];
  assign lineLow  = strb.drive & ~shReg[0];

  AST_PARITY_SENSE: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> ((^shReg) == !$past(evenParity))); // R6
endmodule

// File: rtl/arinc_word_tx.sv
module arinc_word_tx
  import arinc_tx_pkg::*;
#(
  parameter int FAST_DIV = 10,
  parameter int SLOW_DIV = 80,
  parameter int GAP_BITS = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrHalfA,
  input  logic        wrHalfB,
  input  logic [15:0] wrData,
  input  logic        slowRate,
  input  logic        evenParity,
  input  logic        start,
  output logic        busy,
  output logic        lineHigh,
  output logic        lineLow
);
  txStrobe_t strb;

  arinc_tx_ctrl #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV), .GAP_BITS(GAP_BITS)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .slowRate(slowRate),
    .strb(strb), .busy(busy)
  );

  arinc_tx_dp uDp (
    .clk(clk), .rstN(rstN), .wrHalfA(wrHalfA), .wrHalfB(wrHalfB),
    .wrData(wrData), .evenParity(evenParity), .strb(strb),
    .lineHigh(lineHigh), .lineLow(lineLow)
  );

  AST_ONE_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    !(lineHigh && lineLow)); // R8
  AST_NULL_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!lineHigh && !lineLow)); // R9
endmodule

// File: tb/tb_arinc_word_tx.sv
module tb_arinc_word_tx;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rstN = 0, wrHalfA = 0, wrHalfB = 0, slowRate = 0, evenParity = 0, start = 0;
  logic [15:0] wrData = '0;
  logic busy, lineHigh, lineLow;
  int nChecks = 0, nFails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  arinc_word_tx dut (.clk(clk), .rstN(rstN), .wrHalfA(wrHalfA), .wrHalfB(wrHalfB),
    .wrData(wrData), .slowRate(slowRate), .evenParity(evenParity), .start(start),
    .busy(busy), .lineHigh(lineHigh), .lineLow(lineLow));

  task automatic check(input string tag, input logic ok, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // p[i] is word bit i+1 (31 payload bits)
  task automatic loadWord(input logic [30:0] p, input logic junk8);
    logic [15:0] a, b;
    a[15:11] = p[12:8];
    a[10] = p[30];
    a[9] = p[29];
    a[8] = junk8;
    for (int i = 0; i < 8; i++) a[7-i] = p[i];
    b = p[28:13];
    @(negedge clk); wrData = a; wrHalfA = 1;
    @(negedge clk); wrHalfA = 0; wrData = b; wrHalfB = 1;
    @(negedge clk); wrHalfB = 0; wrData = '0;
  endtask

  task automatic sendWord(input string tag, input logic [30:0] p, input logic evenP,
                          input logic slow, input int injectAt);
    int div, half, lineErr, busyErr, firstAct, firstExp;
    logic [31:0] w;
    logic expHi, expLo;
    div = slow ? 80 : 10;
    half = div / 2;
    w = {evenP ? ^p : ~^p, p};
    lineErr = 0; busyErr = 0; firstAct = 0; firstExp = 0;
    slowRate = slow; evenParity = evenP; start = 1;
    @(negedge clk); start = 0;
    for (int t = 0; t < 36*div; t++) begin
      int k, ph;
      k = t / div; ph = t % div;
      expHi = (k < 32) && (ph < half) && w[k];
      expLo = (k < 32) && (ph < half) && !w[k];
      if (lineHigh !== expHi || lineLow !== expLo) begin
        if (lineErr == 0) begin firstAct = {lineHigh, lineLow}; firstExp = {expHi, expLo}; end
        lineErr++;
      end
      if (busy !== 1'b1) busyErr++;
      start = (t == injectAt);
      @(negedge clk);
      start = 0;
    end
    check({tag, " line"}, lineErr == 0, firstAct, firstExp);
    check("R9 busy span", busyErr == 0, busyErr, 0);
    check("R9 busy drops after gap", busy === 1'b0 && !lineHigh && !lineLow, busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy at reset", busy === 1'b0, busy, 0);
    check("R1 line null at reset", !lineHigh && !lineLow, {lineHigh, lineLow}, 0);
    rstN = 1;
    @(negedge clk);
    // fixed patterns, both parity senses
    for (int e = 0; e < 2; e++) begin
      loadWord(31'h0, 0);           sendWord("R6 R8 zeros", 31'h0, e[0], 0, -1);
      loadWord(31'h7FFFFFFF, 0);    sendWord("R6 R8 ones", 31'h7FFFFFFF, e[0], 0, -1);
      loadWord(31'h2AAAAAAA, 0);    sendWord("R6 alt A", 31'h2AAAAAAA, e[0], 0, -1);
      loadWord(31'h55555555, 0);    sendWord("R6 alt B", 31'h55555555, e[0], 0, -1);
    end
    // walking one through every payload position: mapping and order
    for (int i = 0; i < 31; i++) begin
      loadWord(31'(1) << i, 0);
      sendWord("R3 R4 R7 walk", 31'(1) << i, i[0], 0, -1);
    end
    // bus bit 8 ignored
    loadWord(31'h12345678, 1);  sendWord("R5 junk bit8", 31'h12345678, 0, 0, -1);
    loadWord(31'h0, 1);         sendWord("R5 junk bit8 zero", 31'h0, 1, 0, -1);
    // slow rate
    loadWord(31'h4C3B2A19, 0);  sendWord("R2 slow rate", 31'h4C3B2A19, 0, 1, -1);
    // start while busy, in data and in gap
    loadWord(31'h0F0F1234, 0);  sendWord("R10 start mid word", 31'h0F0F1234, 1, 0, 100);
    loadWord(31'h7000000F, 0);  sendWord("R10 start in gap", 31'h7000000F, 0, 0, 330);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule